// File: doc/BRIEF.md
# Color-Sequential Subfield Timing Generator

This block produces the panel-side timing for a microdisplay that has no color filter. Each input frame is shown as three single-color subfields, so the subfield rate is three times the input frame rate. A pixel counter divides the clock to produce a subfield line sync. A line counter divides that line rate to produce a subfield vertical sync. A color index steps through red, green and blue, one step per subfield.

While the panel is being written, a pixel-clock enable is asserted. It is dropped outside the written window so that the panel clock can be stopped. The LED that matches the current color is lit only after the subfield's active lines have been scanned and a further number of settle lines has elapsed. This delay gives the liquid crystal time to respond. The LED stays on until the next subfield starts writing.

An input frame-start pulse restarts the whole sequence at red, line 0, pixel 0. This is how the block locks to the incoming video. Between frame-start pulses, the sequence free-runs.

Top module: `colorSeqTiming`

## Requirements
- R1: After reset, and until the first frameStart, every output is low and colorIdx is 0.
- R2: In the cycle after frameStart is sampled high, subLineSync and subVSync are high and colorIdx is 0. This holds whatever the sequence was doing before.
- R3: While the sequence is running, subLineSync is a one-cycle pulse that repeats every LINE_CLKS cycles.
- R4: subVSync is high only together with the subLineSync of line 0 of a subfield. It therefore repeats every LINE_CLKS*SUB_LINES cycles.
- R5: colorIdx follows the order 0 (red), 1 (green), 2 (blue), then back to 0. It changes only in the first cycle of a subfield, so three subfields take 3*LINE_CLKS*SUB_LINES cycles.
- R6: pixClkEn is high exactly on pixels 0..ACTIVE_CLKS-1 of lines 0..ACTIVE_LINES-1 of each subfield, and low at all other times.
- R7: ledRed, ledGreen and ledBlue are high for colorIdx 0, 1 and 2 respectively. The LED is lit from line ACTIVE_LINES+SETTLE_LINES to the last line of the subfield, and is off elsewhere.
- R8: At most one LED enable is high at a time, and no LED enable is high while pixClkEn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| frameStart | input | 1 | Input frame start; restarts the sequence at red |
| subLineSync | output | 1 | Subfield line sync pulse |
| subVSync | output | 1 | Subfield vertical sync pulse |
| pixClkEn | output | 1 | Panel pixel clock enable during active writing |
| ledRed | output | 1 | Red light source enable |
| ledGreen | output | 1 | Green light source enable |
| ledBlue | output | 1 | Blue light source enable |
| colorIdx | output | 2 | Current subfield color: 0 red, 1 green, 2 blue |

## Verification
The bench aims frame-start pulses at the hard points of the sequence: mid-way through a blue subfield while its LED is lit, on consecutive cycles, and at random phases. A design that restarts late, or that keeps its old color, would show the wrong LED or a missing vertical sync in the cycle after the pulse. The bench also checks the edges of the written window and the first settle line. An off-by-one divider or compare would shift pixClkEn, or light the LED one line early and overlap the scan. It also checks the wrap from blue back to red, where a bad color step would emit an illegal index or skip green.

// File: rtl/colorSeqPkg.sv
package colorSeqPkg;

  typedef enum logic [1:0] {
    COLOR_RED   = 2'd0,
    COLOR_GREEN = 2'd1,
    COLOR_BLUE  = 2'd2
  } colorT;

  // control -> datapath
  typedef struct packed {
    logic restart;
    logic step;
  } seqStrobeT;

  // datapath -> control
  typedef struct packed {
    logic  lineStart;
    logic  subStart;
    logic  pixActive;
    logic  lineActive;
    logic  lightWindow;
    colorT color;
  } seqFlagT;

  function automatic colorT nextColor(colorT c);
    case (c)
      COLOR_RED:   return COLOR_GREEN;
      COLOR_GREEN: return COLOR_BLUE;
      default:     return COLOR_RED;
    endcase
  endfunction

endpackage

// File: rtl/seqCounters.sv
module seqCounters
  import colorSeqPkg::*;
#(
  parameter int LINE_CLKS    = 16,
  parameter int ACTIVE_CLKS  = 10,
  parameter int SUB_LINES    = 12,
  parameter int ACTIVE_LINES = 8,
  parameter int SETTLE_LINES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  seqStrobeT strobe,
  output seqFlagT   flags
);

  localparam int PIX_W  = (LINE_CLKS > 1) ? $clog2(LINE_CLKS) : 1;
  localparam int LINE_W = (SUB_LINES > 1) ? $clog2(SUB_LINES) : 1;
  localparam logic [PIX_W-1:0]  PIX_LAST    = PIX_W'(LINE_CLKS - 1);
  localparam logic [LINE_W-1:0] LINE_LAST   = LINE_W'(SUB_LINES - 1);
  localparam logic [PIX_W-1:0]  PIX_ACT     = PIX_W'(ACTIVE_CLKS);
  localparam logic [LINE_W-1:0] LINE_ACT    = LINE_W'(ACTIVE_LINES);
  localparam logic [LINE_W-1:0] LIGHT_FIRST = LINE_W'(ACTIVE_LINES + SETTLE_LINES);

  logic [PIX_W-1:0]  pixCnt;
  logic [LINE_W-1:0] lineCnt;
  colorT             color;

  logic pixWrap;
  logic lineWrap;

  assign pixWrap  = (pixCnt == PIX_LAST);
  assign lineWrap = (lineCnt == LINE_LAST);

  // first divider: pixels within a subfield line
  always_ff @(posedge clk) begin
    if (rst || strobe.restart) begin
      pixCnt <= '0;
    end else if (strobe.step) begin
      pixCnt <= pixWrap ? '0 : pixCnt + 1'b1;
    end
  end

  // second divider: lines within a subfield
  always_ff @(posedge clk) begin
    if (rst || strobe.restart) begin
      lineCnt <= '0;
    end else if (strobe.step && pixWrap) begin
      lineCnt <= lineWrap ? '0 : lineCnt + 1'b1;
    end
  end

  // subfield color sequence
  always_ff @(posedge clk) begin
    if (rst || strobe.restart) begin
      color <= COLOR_RED;
    end else if (strobe.step && pixWrap && lineWrap) begin
      color <= nextColor(color);
    end
  end

  always_comb begin
    flags.lineStart   = (pixCnt == '0);
    flags.subStart    = (lineCnt == '0);
    flags.pixActive   = (pixCnt < PIX_ACT);
    flags.lineActive  = (lineCnt < LINE_ACT);
    flags.lightWindow = (lineCnt >= LIGHT_FIRST);
    flags.color       = color;
  end

endmodule

// File: rtl/seqControl.sv
module seqControl
  import colorSeqPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      frameStart,
  input  seqFlagT   flags,
  output seqStrobeT strobe,
  output logic      subLineSync,
  output logic      subVSync,
  output logic      pixClkEn,
  output logic      ledRed,
  output logic      ledGreen,
  output logic      ledBlue,
  output logic [1:0] colorIdx
);

  logic running;
  logic lightOn;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
    end else if (frameStart) begin
      running <= 1'b1;
    end
  end

  always_comb begin
    strobe.restart = frameStart;
    strobe.step    = running;
  end

  assign lightOn     = running && flags.lightWindow;
  assign subLineSync = running && flags.lineStart;
  assign subVSync    = running && flags.lineStart && flags.subStart;
  assign pixClkEn    = running && flags.pixActive && flags.lineActive;
  assign ledRed      = lightOn && (flags.color == COLOR_RED);
  assign ledGreen    = lightOn && (flags.color == COLOR_GREEN);
  assign ledBlue     = lightOn && (flags.color == COLOR_BLUE);
  assign colorIdx    = flags.color;

endmodule

// File: rtl/colorSeqTiming.sv
module colorSeqTiming
  import colorSeqPkg::*;
#(
  parameter int LINE_CLKS    = 16,
  parameter int ACTIVE_CLKS  = 10,
  parameter int SUB_LINES    = 12,
  parameter int ACTIVE_LINES = 8,
  parameter int SETTLE_LINES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frameStart,
  output logic       subLineSync,
  output logic       subVSync,
  output logic       pixClkEn,
  output logic       ledRed,
  output logic       ledGreen,
  output logic       ledBlue,
  output logic [1:0] colorIdx
);

  seqStrobeT strobe;
  seqFlagT   flags;

  seqCounters #(
    .LINE_CLKS   (LINE_CLKS),
    .ACTIVE_CLKS (ACTIVE_CLKS),
    .SUB_LINES   (SUB_LINES),
    .ACTIVE_LINES(ACTIVE_LINES),
    .SETTLE_LINES(SETTLE_LINES)
  ) i_seqCounters (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .flags (flags)
  );

  seqControl i_seqControl (
    .clk        (clk),
    .rst        (rst),
    .frameStart (frameStart),
    .flags      (flags),
    .strobe     (strobe),
    .subLineSync(subLineSync),
    .subVSync   (subVSync),
    .pixClkEn   (pixClkEn),
    .ledRed     (ledRed),
    .ledGreen   (ledGreen),
    .ledBlue    (ledBlue),
    .colorIdx   (colorIdx)
  );

endmodule

// File: rtl/colorSeqTimingChecker.sv
module colorSeqTimingChecker (
  input logic       clk,
  input logic       rst,
  input logic       frameStart,
  input logic       subLineSync,
  input logic       subVSync,
  input logic       pixClkEn,
  input logic       ledRed,
  input logic       ledGreen,
  input logic       ledBlue,
  input logic [1:0] colorIdx
);

  assert_restart_red_R2: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> (subVSync && subLineSync && colorIdx == 2'd0));

  assert_vsync_on_line_R4: assert property (@(posedge clk) disable iff (rst)
    subVSync |-> subLineSync);

  assert_legal_color_R5: assert property (@(posedge clk) disable iff (rst)
    colorIdx != 2'd3);

  assert_color_steps_at_subfield_R5: assert property (@(posedge clk) disable iff (rst)
    (colorIdx != $past(colorIdx)) |-> subVSync);

  assert_led_match_R7: assert property (@(posedge clk) disable iff (rst)
    ledGreen |-> colorIdx == 2'd1);

  assert_led_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ledRed, ledGreen, ledBlue}));

  assert_dark_while_writing_R8: assert property (@(posedge clk) disable iff (rst)
    pixClkEn |-> !(ledRed || ledGreen || ledBlue));

endmodule

bind colorSeqTiming colorSeqTimingChecker i_colorSeqTimingChecker (.*);

// File: tb/test_colorSeqTiming.sv
module test_colorSeqTiming;

  localparam int LINE_CLKS    = 16;
  localparam int ACTIVE_CLKS  = 10;
  localparam int SUB_LINES    = 12;
  localparam int ACTIVE_LINES = 8;
  localparam int SETTLE_LINES = 2;
  localparam int SUB_CLKS     = LINE_CLKS * SUB_LINES;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frameStart = 1'b0;
  logic       subLineSync, subVSync, pixClkEn, ledRed, ledGreen, ledBlue;
  logic [1:0] colorIdx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // independent reference state
  bit mRun = 1'b0;
  int mPix = 0;
  int mLine = 0;
  int mColor = 0;

  colorSeqTiming #(
    .LINE_CLKS(LINE_CLKS), .ACTIVE_CLKS(ACTIVE_CLKS), .SUB_LINES(SUB_LINES),
    .ACTIVE_LINES(ACTIVE_LINES), .SETTLE_LINES(SETTLE_LINES)
  ) i_colorSeqTiming (
    .clk(clk), .rst(rst), .frameStart(frameStart),
    .subLineSync(subLineSync), .subVSync(subVSync), .pixClkEn(pixClkEn),
    .ledRed(ledRed), .ledGreen(ledGreen), .ledBlue(ledBlue), .colorIdx(colorIdx)
  );

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void modelStep(bit fs);
    if (fs) begin
      mRun = 1'b1; mPix = 0; mLine = 0; mColor = 0;
    end else if (mRun) begin
      if (mPix == LINE_CLKS - 1) begin
        mPix = 0;
        if (mLine == SUB_LINES - 1) begin
          mLine = 0;
          mColor = (mColor + 1) % 3;
        end else mLine++;
      end else mPix++;
    end
  endfunction

  function automatic int expLed(int c);
    return (mRun && mLine >= ACTIVE_LINES + SETTLE_LINES && mColor == c) ? 1 : 0;
  endfunction

  task automatic checkAll();
    chk("R3 subLineSync", int'(subLineSync), int'(mRun && mPix == 0));
    chk("R4 subVSync", int'(subVSync), int'(mRun && mPix == 0 && mLine == 0));
    chk("R5 colorIdx", int'(colorIdx), mColor);
    chk("R6 pixClkEn", int'(pixClkEn),
        int'(mRun && mPix < ACTIVE_CLKS && mLine < ACTIVE_LINES));
    chk("R7 ledRed", int'(ledRed), expLed(0));
    chk("R7 ledGreen", int'(ledGreen), expLed(1));
    chk("R7 ledBlue", int'(ledBlue), expLed(2));
    chk("R8 led count", int'(ledRed) + int'(ledGreen) + int'(ledBlue) > 1 ? 1 : 0, 0);
  endtask

  // one clock with the given frameStart; checks afterwards
  task automatic cycle(bit fs);
    frameStart = fs;
    @(posedge clk);
    #2;
    frameStart = 1'b0;
    modelStep(fs);
    checkAll();
    if (fs) begin
      chk("R2 vsync after restart", int'(subVSync), 1);
      chk("R2 red after restart", int'(colorIdx), 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 reset sync", int'(subLineSync || subVSync || pixClkEn), 0);
    chk("R1 reset leds", int'(ledRed || ledGreen || ledBlue), 0);
    chk("R1 reset color", int'(colorIdx), 0);
    rst = 1'b0;
    // R1 idle until first frameStart
    for (int i = 0; i < 20; i++) cycle(1'b0);
    chk("R1 idle outputs", int'(subLineSync || pixClkEn || ledRed), 0);

    // full red/green/blue pass and wrap back to red (R5)
    cycle(1'b1);
    for (int i = 0; i < 3 * SUB_CLKS + 5; i++) cycle(1'b0);
    chk("R5 wrapped to red", int'(colorIdx), 0);

    // restart in the middle of a lit blue subfield (R2)
    for (int i = 0; i < 2 * SUB_CLKS + (ACTIVE_LINES + SETTLE_LINES) * LINE_CLKS + 3; i++)
      cycle(1'b0);
    chk("R7 blue lit before restart", int'(ledBlue), 1);
    cycle(1'b1);
    chk("R2 blue dark after restart", int'(ledBlue), 0);

    // back-to-back frameStart pulses
    cycle(1'b1);
    cycle(1'b1);
    cycle(1'b0);

    // random frame starts at arbitrary phases
    for (int i = 0; i < 20000; i++) cycle(($urandom % 900) == 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule